// File: doc/BRIEF.md
# Shadowed Overlay Window Register Bank

This block keeps the overlay setup for the five hardware windows of a display controller. For each window, software can program the frame buffer start and end addresses, the line offset and page width, the top-left and bottom-right screen coordinates, a window enable bit and a separate DMA channel enable bit. Windows 0 to 2 also have a buffer size register, counted in words. Every write goes to a pending copy of the register. Register reads return that pending copy.

Scanout uses a second copy, the live copy. The pending copy moves into the live copy only on a vertical-sync pulse, and only for windows whose protect bit is clear. Software sets a window's protect bit, rewrites several of that window's registers, and then clears the bit. All of those changes then reach the live copy together at the next sync. The live values of every window are driven on flat output buses. A debug read port gives the live copy of any single register.

Top module: `win_shadow_bank`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every pending value, every live value and every protect bit reads zero. This covers all live output buses and both read ports.
- R2: A write with `wrEn` high, window `wrWin` (0 to 4) and field `wrReg` appears on `rdData` after that clock edge. The live copy of that field does not change until a sync pulse arrives. Field codes: 0 start address, 1 end address, 2 geometry (page width in bits 12:0, line offset in bits 25:13), 3 top-left (x in bits 10:0, y in bits 21:11), 4 bottom-right (same packing), 5 control, 6 size in words (bits 23:0), 7 protect (bit 0).
- R3: A clock edge with `vsyncPulse` high copies every pending field of each unprotected window into its live copy.
- R4: A sync pulse does not change the live copy of a window whose protect bit is set, even when new pending values exist.
- R5: After a protect bit is cleared, the window's pending values reach the live copy at the next sync pulse, and not earlier.
- R6: Protect bits act per window. Writing one window's protect bit leaves the other windows' protect bits unchanged. Protecting one window does not stop the others from loading.
- R7: When a write and a sync pulse fall on the same edge, the live copy receives the value that was pending before the write. The new value stays pending until the next sync pulse.
- R8: Only windows 0, 1 and 2 have a size register. A size write to window 3 or 4 is ignored, and those windows read size as zero on both read ports.
- R9: In the control field, bit 0 is the window enable and bit 1 is the DMA channel enable. Their live values appear on separate per-window bits of `liveWinEn` and `liveDmaEn`.
- R10: Writes to window indices 5 to 7 are ignored, and reads of those indices return zero on both read ports.
- R11: A protect bit written on the same edge as a sync pulse takes effect only from the next edge. The load on that edge follows the previous protect value.
- R12: Data bits above a field's width are dropped on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsyncPulse | input | 1 | One-cycle vertical-sync strobe |
| wrEn | input | 1 | Register write strobe |
| wrWin | input | 3 | Window index of the write |
| wrReg | input | 3 | Field code of the write |
| wrData | input | 32 | Write data |
| rdWin | input | 3 | Window index of the pending-copy read |
| rdReg | input | 3 | Field code of the pending-copy read |
| rdData | output | 32 | Pending value of the selected field |
| dbgWin | input | 3 | Window index of the live-copy read |
| dbgReg | input | 3 | Field code of the live-copy read |
| dbgData | output | 32 | Live value of the selected field |
| liveStartAddr | output | 160 | Live start address, 32 bits per window, window 0 in the low bits |
| liveEndAddr | output | 160 | Live end address, 32 bits per window |
| liveGeom | output | 130 | Live geometry field, 26 bits per window |
| liveTopLeft | output | 110 | Live top-left coordinate, 22 bits per window |
| liveBotRight | output | 110 | Live bottom-right coordinate (last pixel), 22 bits per window |
| liveSize | output | 72 | Live size in words, 24 bits for each of windows 0 to 2 |
| liveWinEn | output | 5 | Live window enable, one bit per window |
| liveDmaEn | output | 5 | Live DMA channel enable, one bit per window |

## Verification
Both read ports are combinational over the stored registers. A written field therefore appears on `rdData` in the cycle after the write edge. A field loaded by a sync pulse appears on `dbgData` and on the live buses in the cycle after that pulse's edge. The bench applies each vector on a falling edge and samples the results on the next falling edge, so exactly one rising edge falls between stimulus and check. Same-edge collisions of a write or a protect change with a sync pulse are placed in single vectors. Later vectors then show when the deferred value lands.

// File: rtl/winbank_pkg.sv
package winbank_pkg;
  localparam int WIN_COUNT       = 5;
  localparam int SIZED_WIN_COUNT = 3;
  localparam int REG_COUNT       = 8;
  localparam int PLAIN_FIELDS    = 6;
  localparam int DATA_W          = 32;
  localparam int IDX_W           = 3;

  typedef enum logic [IDX_W-1:0] {
    FLD_START    = 3'd0,
    FLD_END      = 3'd1,
    FLD_GEOM     = 3'd2,
    FLD_TOPLEFT  = 3'd3,
    FLD_BOTRIGHT = 3'd4,
    FLD_CTRL     = 3'd5,
    FLD_WSIZE    = 3'd6,
    FLD_PROT     = 3'd7
  } fieldSel_t;

  typedef struct packed {
    logic [WIN_COUNT-1:0][PLAIN_FIELDS-1:0] fieldStb;
    logic [SIZED_WIN_COUNT-1:0]             sizeStb;
    logic [WIN_COUNT-1:0]                   loadStb;
  } bankStb_t;
endpackage

// File: rtl/winbank_ctrl.sv
module winbank_ctrl
  import winbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 vsyncPulse,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrWin,
  input  logic [IDX_W-1:0]     wrReg,
  input  logic                 wrProtBit,
  output bankStb_t             stb,
  output logic [WIN_COUNT-1:0] protVec
);

  // Decode the write into per-window strobes; loads follow the protect bits held before this edge.
  always_comb begin
    stb = '0;
    for (int w = 0; w < WIN_COUNT; w++) begin
      for (int r = 0; r < PLAIN_FIELDS; r++) begin
        stb.fieldStb[w][r] = wrEn && (wrWin == IDX_W'(w)) && (wrReg == IDX_W'(r));
      end
      stb.loadStb[w] = vsyncPulse && !protVec[w];
    end
    for (int w = 0; w < SIZED_WIN_COUNT; w++) begin
      stb.sizeStb[w] = wrEn && (wrWin == IDX_W'(w)) && (wrReg == FLD_WSIZE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protVec <= '0;
    end else begin
      for (int w = 0; w < WIN_COUNT; w++) begin
        if (wrEn && (wrWin == IDX_W'(w)) && (wrReg == FLD_PROT)) begin
          protVec[w] <= wrProtBit;
        end
      end
    end
  end

endmodule

// File: rtl/winbank_dp.sv
module winbank_dp
  import winbank_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 11,
  parameter int PW_W    = 13,
  parameter int OFS_W   = 13,
  parameter int SIZE_W  = 24
)(
  input  logic                                clk,
  input  logic                                rstN,
  input  bankStb_t                            stb,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [WIN_COUNT-1:0]                protVec,
  input  logic [IDX_W-1:0]                    rdWin,
  input  logic [IDX_W-1:0]                    rdReg,
  output logic [DATA_W-1:0]                   rdData,
  input  logic [IDX_W-1:0]                    dbgWin,
  input  logic [IDX_W-1:0]                    dbgReg,
  output logic [DATA_W-1:0]                   dbgData,
  output logic [WIN_COUNT*ADDR_W-1:0]         liveStartAddr,
  output logic [WIN_COUNT*ADDR_W-1:0]         liveEndAddr,
  output logic [WIN_COUNT*(PW_W+OFS_W)-1:0]   liveGeom,
  output logic [WIN_COUNT*2*COORD_W-1:0]      liveTopLeft,
  output logic [WIN_COUNT*2*COORD_W-1:0]      liveBotRight,
  output logic [SIZED_WIN_COUNT*SIZE_W-1:0]   liveSize,
  output logic [WIN_COUNT-1:0]                liveWinEn,
  output logic [WIN_COUNT-1:0]                liveDmaEn
);
  localparam int GEOM_W = PW_W + OFS_W;
  localparam int PT_W   = 2 * COORD_W;

  logic [DATA_W-1:0] actView  [WIN_COUNT][REG_COUNT];
  logic [DATA_W-1:0] liveView [WIN_COUNT][REG_COUNT];

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    logic [ADDR_W-1:0] startA, startL, endA, endL;
    logic [GEOM_W-1:0] geomA, geomL;
    logic [PT_W-1:0]   tlA, tlL, brA, brL;
    logic [1:0]        ctlA, ctlL;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startA <= '0; endA <= '0; geomA <= '0; tlA <= '0; brA <= '0; ctlA <= '0;
        startL <= '0; endL <= '0; geomL <= '0; tlL <= '0; brL <= '0; ctlL <= '0;
      end else begin
        if (stb.fieldStb[w][FLD_START])    startA <= wrData[ADDR_W-1:0];
        if (stb.fieldStb[w][FLD_END])      endA   <= wrData[ADDR_W-1:0];
        if (stb.fieldStb[w][FLD_GEOM])     geomA  <= wrData[GEOM_W-1:0];
        if (stb.fieldStb[w][FLD_TOPLEFT])  tlA    <= wrData[PT_W-1:0];
        if (stb.fieldStb[w][FLD_BOTRIGHT]) brA    <= wrData[PT_W-1:0];
        if (stb.fieldStb[w][FLD_CTRL])     ctlA   <= wrData[1:0];
        if (stb.loadStb[w]) begin
          startL <= startA; endL <= endA; geomL <= geomA;
          tlL    <= tlA;    brL  <= brA;  ctlL  <= ctlA;
        end
      end
    end

    assign actView[w][FLD_START]     = DATA_W'(startA);
    assign actView[w][FLD_END]       = DATA_W'(endA);
    assign actView[w][FLD_GEOM]      = DATA_W'(geomA);
    assign actView[w][FLD_TOPLEFT]   = DATA_W'(tlA);
    assign actView[w][FLD_BOTRIGHT]  = DATA_W'(brA);
    assign actView[w][FLD_CTRL]      = DATA_W'(ctlA);
    assign actView[w][FLD_PROT]      = DATA_W'(protVec[w]);
    assign liveView[w][FLD_START]    = DATA_W'(startL);
    assign liveView[w][FLD_END]      = DATA_W'(endL);
    assign liveView[w][FLD_GEOM]     = DATA_W'(geomL);
    assign liveView[w][FLD_TOPLEFT]  = DATA_W'(tlL);
    assign liveView[w][FLD_BOTRIGHT] = DATA_W'(brL);
    assign liveView[w][FLD_CTRL]     = DATA_W'(ctlL);
    assign liveView[w][FLD_PROT]     = DATA_W'(protVec[w]);

    assign liveStartAddr[w*ADDR_W +: ADDR_W] = startL;
    assign liveEndAddr[w*ADDR_W +: ADDR_W]   = endL;
    assign liveGeom[w*GEOM_W +: GEOM_W]      = geomL;
    assign liveTopLeft[w*PT_W +: PT_W]       = tlL;
    assign liveBotRight[w*PT_W +: PT_W]      = brL;
    assign liveWinEn[w]                      = ctlL[0];
    assign liveDmaEn[w]                      = ctlL[1];

    if (w < SIZED_WIN_COUNT) begin : g_sized
      logic [SIZE_W-1:0] sizeA, sizeL;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sizeA <= '0;
          sizeL <= '0;
        end else begin
          if (stb.sizeStb[w]) sizeA <= wrData[SIZE_W-1:0];
          if (stb.loadStb[w]) sizeL <= sizeA;
        end
      end
      assign actView[w][FLD_WSIZE]          = DATA_W'(sizeA);
      assign liveView[w][FLD_WSIZE]         = DATA_W'(sizeL);
      assign liveSize[w*SIZE_W +: SIZE_W]   = sizeL;
    end else begin : g_unsized
      assign actView[w][FLD_WSIZE]  = '0;
      assign liveView[w][FLD_WSIZE] = '0;
    end
  end

  always_comb begin
    rdData  = '0;
    dbgData = '0;
    if (rdWin < IDX_W'(WIN_COUNT))  rdData  = actView[rdWin][rdReg];
    if (dbgWin < IDX_W'(WIN_COUNT)) dbgData = liveView[dbgWin][dbgReg];
  end

endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import winbank_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 11,
  parameter int PW_W    = 13,
  parameter int OFS_W   = 13,
  parameter int SIZE_W  = 24
)(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                vsyncPulse,
  input  logic                                wrEn,
  input  logic [IDX_W-1:0]                    wrWin,
  input  logic [IDX_W-1:0]                    wrReg,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [IDX_W-1:0]                    rdWin,
  input  logic [IDX_W-1:0]                    rdReg,
  output logic [DATA_W-1:0]                   rdData,
  input  logic [IDX_W-1:0]                    dbgWin,
  input  logic [IDX_W-1:0]                    dbgReg,
  output logic [DATA_W-1:0]                   dbgData,
  output logic [WIN_COUNT*ADDR_W-1:0]         liveStartAddr,
  output logic [WIN_COUNT*ADDR_W-1:0]         liveEndAddr,
  output logic [WIN_COUNT*(PW_W+OFS_W)-1:0]   liveGeom,
  output logic [WIN_COUNT*2*COORD_W-1:0]      liveTopLeft,
  output logic [WIN_COUNT*2*COORD_W-1:0]      liveBotRight,
  output logic [SIZED_WIN_COUNT*SIZE_W-1:0]   liveSize,
  output logic [WIN_COUNT-1:0]                liveWinEn,
  output logic [WIN_COUNT-1:0]                liveDmaEn
);

  bankStb_t             stb;
  logic [WIN_COUNT-1:0] protVec;

  winbank_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .vsyncPulse (vsyncPulse),
    .wrEn       (wrEn),
    .wrWin      (wrWin),
    .wrReg      (wrReg),
    .wrProtBit  (wrData[0]),
    .stb        (stb),
    .protVec    (protVec)
  );

  winbank_dp #(
    .ADDR_W (ADDR_W), .COORD_W (COORD_W), .PW_W (PW_W), .OFS_W (OFS_W), .SIZE_W (SIZE_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .wrData        (wrData),
    .protVec       (protVec),
    .rdWin         (rdWin),
    .rdReg         (rdReg),
    .rdData        (rdData),
    .dbgWin        (dbgWin),
    .dbgReg        (dbgReg),
    .dbgData       (dbgData),
    .liveStartAddr (liveStartAddr),
    .liveEndAddr   (liveEndAddr),
    .liveGeom      (liveGeom),
    .liveTopLeft   (liveTopLeft),
    .liveBotRight  (liveBotRight),
    .liveSize      (liveSize),
    .liveWinEn     (liveWinEn),
    .liveDmaEn     (liveDmaEn)
  );

endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk
  import winbank_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input logic                        clk,
  input logic                        rstN,
  input logic                        vsyncPulse,
  input logic                        wrEn,
  input logic [IDX_W-1:0]            wrWin,
  input logic [IDX_W-1:0]            wrReg,
  input logic [1:0]                  wrCtl,
  input logic [WIN_COUNT-1:0]        protVec,
  input logic [WIN_COUNT*ADDR_W-1:0] liveStartAddr,
  input logic [WIN_COUNT-1:0]        liveWinEn,
  input logic [WIN_COUNT-1:0]        liveDmaEn
);

  // R2: without a sync pulse the live copy holds
  a_r2_live_hold: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncPulse |=> ($stable(liveStartAddr) && $stable(liveWinEn) && $stable(liveDmaEn)))
    else $error("a_r2_live_hold");

  // R3: a control write followed by an unprotected sync lands in the live copy
  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWin == 3'd0 && wrReg == FLD_CTRL) ##1
    (vsyncPulse && !protVec[0] && !(wrEn && wrWin == 3'd0 && wrReg == FLD_CTRL))
    |=> (liveWinEn[0] == $past(wrCtl[0], 2) && liveDmaEn[0] == $past(wrCtl[1], 2)))
    else $error("a_r3_ctrl_load");

  // R10: writes to nonexistent windows leave every protect bit alone
  a_r10_bad_window: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWin >= IDX_W'(WIN_COUNT)) |=> $stable(protVec))
    else $error("a_r10_bad_window");

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win_chk
    localparam logic [WIN_COUNT-1:0] OTHERS = ~(WIN_COUNT'(1) << w);

    // R4: a protected window keeps its live values across a sync pulse
    a_r4_protect_hold: assert property (@(posedge clk) disable iff (!rstN)
      (vsyncPulse && protVec[w]) |=>
      ($stable(liveStartAddr[w*ADDR_W +: ADDR_W]) && $stable(liveWinEn[w]) && $stable(liveDmaEn[w])))
      else $error("a_r4_protect_hold");

    // R6: a protect write touches only its own window
    a_r6_protect_local: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrReg == FLD_PROT && wrWin == IDX_W'(w)) |=> $stable(protVec & OTHERS))
      else $error("a_r6_protect_local");
  end

endmodule

bind win_shadow_bank win_shadow_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .vsyncPulse    (vsyncPulse),
  .wrEn          (wrEn),
  .wrWin         (wrWin),
  .wrReg         (wrReg),
  .wrCtl         (wrData[1:0]),
  .protVec       (protVec),
  .liveStartAddr (liveStartAddr),
  .liveWinEn     (liveWinEn),
  .liveDmaEn     (liveDmaEn)
);

// File: tb/test_win_shadow_bank.sv
`timescale 1ns/1ps
module test_win_shadow_bank;
  localparam logic [2:0] F_START = 3'd0, F_END = 3'd1, F_TL = 3'd3,
                         F_CTRL = 3'd5, F_SIZE = 3'd6, F_PROT = 3'd7;

  typedef struct packed {
    logic        wrEn;
    logic [2:0]  wrWin;
    logic [2:0]  wrReg;
    logic [31:0] wrData;
    logic        vsync;
    logic [2:0]  chkWin;
    logic [2:0]  chkReg;
    logic [31:0] expRd;
    logic [31:0] expDbg;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd1, F_START, 32'h1000_0000, 1'b0, 3'd1, F_START, 32'h1000_0000, 32'h0,         8'd2},  // R2
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd1, F_START, 32'h1000_0000, 32'h1000_0000, 8'd3},  // R3
    '{1'b1, 3'd1, F_PROT,  32'h1,         1'b0, 3'd1, F_PROT,  32'h1,         32'h1,         8'd4},  // R4
    '{1'b1, 3'd1, F_START, 32'h2000_0000, 1'b0, 3'd1, F_START, 32'h2000_0000, 32'h1000_0000, 8'd2},  // R2
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd1, F_START, 32'h2000_0000, 32'h1000_0000, 8'd4},  // R4
    '{1'b1, 3'd1, F_PROT,  32'h0,         1'b0, 3'd1, F_START, 32'h2000_0000, 32'h1000_0000, 8'd5},  // R5
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd1, F_START, 32'h2000_0000, 32'h2000_0000, 8'd5},  // R5
    '{1'b1, 3'd2, F_CTRL,  32'h3,         1'b1, 3'd2, F_CTRL,  32'h3,         32'h0,         8'd7},  // R7
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd2, F_CTRL,  32'h3,         32'h3,         8'd7},  // R7
    '{1'b1, 3'd3, F_SIZE,  32'h123,       1'b1, 3'd3, F_SIZE,  32'h0,         32'h0,         8'd8},  // R8
    '{1'b1, 3'd0, F_SIZE,  32'hFFFF_FFFF, 1'b0, 3'd0, F_SIZE,  32'h00FF_FFFF, 32'h0,         8'd12}, // R12
    '{1'b1, 3'd2, F_TL,    32'hFFFF_FFFF, 1'b0, 3'd2, F_TL,    32'h003F_FFFF, 32'h0,         8'd12}, // R12
    '{1'b1, 3'd2, F_PROT,  32'h1,         1'b1, 3'd2, F_TL,    32'h003F_FFFF, 32'h003F_FFFF, 8'd11}, // R11
    '{1'b1, 3'd2, F_TL,    32'h5,         1'b1, 3'd2, F_TL,    32'h5,         32'h003F_FFFF, 8'd4},  // R4
    '{1'b1, 3'd4, F_END,   32'h44,        1'b0, 3'd4, F_END,   32'h44,        32'h0,         8'd2},  // R2
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd4, F_END,   32'h44,        32'h44,        8'd6},  // R6
    '{1'b0, 3'd0, F_START, 32'h0,         1'b0, 3'd2, F_TL,    32'h5,         32'h003F_FFFF, 8'd6},  // R6
    '{1'b1, 3'd5, F_START, 32'h77,        1'b0, 3'd5, F_START, 32'h0,         32'h0,         8'd10}, // R10
    '{1'b0, 3'd0, F_START, 32'h0,         1'b1, 3'd5, F_START, 32'h0,         32'h0,         8'd10}  // R10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vsyncPulse = 1'b0, wrEn = 1'b0;
  logic [2:0] wrWin = '0, wrReg = '0, rdWin = '0, rdReg = '0, dbgWin = '0, dbgReg = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, dbgData;
  logic [159:0] liveStartAddr, liveEndAddr;
  logic [129:0] liveGeom;
  logic [109:0] liveTopLeft, liveBotRight;
  logic [71:0]  liveSize;
  logic [4:0]   liveWinEn, liveDmaEn;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  win_shadow_bank i_win_shadow_bank (
    .clk(clk), .rstN(rstN), .vsyncPulse(vsyncPulse), .wrEn(wrEn), .wrWin(wrWin),
    .wrReg(wrReg), .wrData(wrData), .rdWin(rdWin), .rdReg(rdReg), .rdData(rdData),
    .dbgWin(dbgWin), .dbgReg(dbgReg), .dbgData(dbgData), .liveStartAddr(liveStartAddr),
    .liveEndAddr(liveEndAddr), .liveGeom(liveGeom), .liveTopLeft(liveTopLeft),
    .liveBotRight(liveBotRight), .liveSize(liveSize), .liveWinEn(liveWinEn), .liveDmaEn(liveDmaEn)
  );

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [2:0] win, input logic [2:0] fld,
                       input logic [31:0] data, input logic vs);
    wrEn = en; wrWin = win; wrReg = fld; wrData = data; vsyncPulse = vs;
  endtask

  task automatic checkAllZero(input string req);
    check(req, liveStartAddr, '0);
    check(req, liveEndAddr, '0);
    check(req, {liveGeom, liveTopLeft}, '0);
    check(req, {liveBotRight, liveSize}, '0);
    check(req, {liveWinEn, liveDmaEn}, '0);
    check(req, rdData, '0);
    check(req, dbgData, '0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: state under reset
    rdWin = 3'd1; rdReg = F_PROT; dbgWin = 3'd1; dbgReg = F_START;
    repeat (3) @(negedge clk);
    checkAllZero("R1 reset");
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].wrEn, VECS[i].wrWin, VECS[i].wrReg, VECS[i].wrData, VECS[i].vsync);
      rdWin = VECS[i].chkWin; rdReg = VECS[i].chkReg;
      dbgWin = VECS[i].chkWin; dbgReg = VECS[i].chkReg;
      @(negedge clk);
      check($sformatf("R%0d vec%0d pending", VECS[i].req, i), rdData, VECS[i].expRd);
      check($sformatf("R%0d vec%0d live", VECS[i].req, i), dbgData, VECS[i].expDbg);
    end
    drive(1'b0, 3'd0, F_START, 32'h0, 1'b0);
    @(negedge clk);

    // R9: window 2 control = 3 is live
    check("R9 winEn", liveWinEn, 5'b00100);
    check("R9 dmaEn", liveDmaEn, 5'b00100);
    // R9: DMA enable without window enable on window 4
    drive(1'b1, 3'd4, F_CTRL, 32'h2, 1'b1);
    @(negedge clk);
    drive(1'b0, 3'd0, F_START, 32'h0, 1'b1);
    @(negedge clk);
    drive(1'b0, 3'd0, F_START, 32'h0, 1'b0);
    check("R9 winEn separate", liveWinEn, 5'b00100);
    check("R9 dmaEn separate", liveDmaEn, 5'b10100);
    // R3: start address bus of window 1
    check("R3 live start bus", liveStartAddr[32 +: 32], 32'h2000_0000);
    // R8: size buses, window 0 loaded, windows 1 and 2 untouched
    check("R8 live size bus", liveSize, {48'h0, 24'hFF_FFFF});
    // R12: top-left of window 2 on its live bus
    check("R12 live topleft bus", liveTopLeft[44 +: 22], 22'h3F_FFFF);

    // R1: reset in mid-run clears everything
    rdWin = 3'd1; rdReg = F_START; dbgWin = 3'd2; dbgReg = F_PROT;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkAllZero("R1 mid-run reset");
    rstN = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule